// File: doc/BRIEF.md
# Read-Only I2C Converter Result Slave

This block is the digital front of a single-channel differential converter. It runs a small operating sequence: start a conversion, hold the finished result while asleep, and hand it out over a two-wire I2C bus when a master reads it. Bus lines are oversampled on the system clock. The block drives the data line only through a pull-down enable, which the pad turns into an open-drain output.

A converter core is attached through a start pulse and a done strobe. On done, the core presents a signed, already-scaled difference value (32768 × diff / ref) that is wider than the output code. The block saturates that value to 16 bits and formats it for transmission. A read returns two bytes. Once the result has been read, or an acknowledged read is closed by a STOP, the block launches the next conversion.

Top module: `adc_result_i2c_slave`

## Requirements
- R1: Only the address byte 0x29 (7-bit address 0010100 followed by read bit 1) selects the block. Any other address, or that address with write bit 0, gets no ACK. The data line stays released until the next START, and both the held result and the conversion state are left as they were.
- R2: After reset the data line is released, one conversion is launched, and the block is in CONVERSION. When the core signals done, the block moves to SLEEP.
- R3: A correct address received while a conversion is running is answered with NAK: the data line stays released in the ninth clock.
- R4: A correct address received in SLEEP is answered with ACK: the data line is pulled low in the ninth clock. The block then enters DATA_OUTPUT.
- R5: The result goes out as 16 bits, MSB first. The transmitted word is the clamped two's-complement code with its top bit inverted, so the first bit is 1 when the code is zero or positive.
- R6: The pull-down enable changes only while SCL is low, so every bit is stable while SCL is high.
- R7: Values above 32767 are sent as code 32767 (word 0xFFFF). Values below -32768 are sent as code -32768 (word 0x0000).
- R8: A master ACK after the first byte continues with the second byte. A master NACK releases the data line and ends the transfer.
- R9: A STOP that follows an acknowledged read launches a new conversion, even if no bits or only part of the word were read.
- R10: When the sixteenth bit has been shifted out, a new conversion is launched at once, without waiting for a STOP. The STOP that follows does not launch another one.
- R11: A repeated START is handled exactly like a START. After a partial read closed by a repeated START, the held result is kept and a new read returns the same word.
- R12: Each conversion start is a single-cycle pulse, asserted only on entry to CONVERSION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High pulls the data line low (open-drain enable) |
| conv_start_o | output | 1 | Single-cycle pulse that launches a conversion |
| conv_done_i | input | 1 | Core strobe: the conversion value is valid |
| conv_data_i | input | DIFF_W | Signed scaled difference value from the core |

## Verification
The assertions assume a bus master that changes the data line only while SCL is low, except to form START and STOP. They also assume the master never tries to form a START or STOP while the block is pulling the line low, and that the core raises done only while a conversion it was asked for is running. The bench master holds each bus phase for many system clocks, far longer than the synchronizer and glitch filter delay. It only ever releases the line, never drives it high, and it closes a read with a NACK before any STOP, except where the held bit is already a 1. The core stub answers each start pulse exactly once, after a fixed delay.

// File: rtl/adcsl_pkg.sv
package adcsl_pkg;

    localparam int CODE_W = 16;

    typedef enum logic [1:0] {
        OP_CONV  = 2'd0,
        OP_SLEEP = 2'd1,
        OP_DOUT  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        B_IDLE = 3'd0,
        B_ADDR = 3'd1,
        B_AACK = 3'd2,
        B_TX   = 3'd3,
        B_MACK = 3'd4
    } bus_e;

    typedef struct packed {
        op_e               op;
        bus_e              bus;
        logic [3:0]        cnt;
        logic [7:0]        addr_sh;
        logic [CODE_W-1:0] tx_sh;
        logic [CODE_W-1:0] res;
        logic              byte_hi;
        logic              mack;
        logic              rd_valid;
        logic              pull;
        logic              cstart;
        logic              kick;
        logic              scl_p;
        logic              sda_p;
    } slv_state_t;

endpackage

// File: rtl/adcsl_line_filter.sv
module adcsl_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
        cnt_d  = '0;
        filt_d = filt_q;
        if (sync_q[SYNC_STAGES-1] != filt_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_d = sync_q[SYNC_STAGES-1];
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/adcsl_fmt.sv
module adcsl_fmt import adcsl_pkg::*; #(
    parameter int DIFF_W = 20
) (
    input  logic signed [DIFF_W-1:0] val_i,
    output logic        [CODE_W-1:0] word_o
);
    localparam logic signed [DIFF_W-1:0] MAXV =
        {{(DIFF_W-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}};
    localparam logic signed [DIFF_W-1:0] MINV =
        {{(DIFF_W-CODE_W+1){1'b1}}, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] code;

    always_comb begin
        if (val_i > MAXV) begin
            code = {1'b0, {(CODE_W-1){1'b1}}};
        end else if (val_i < MINV) begin
            code = {1'b1, {(CODE_W-1){1'b0}}};
        end else begin
            code = val_i[CODE_W-1:0];
        end
        word_o = {~code[CODE_W-1], code[CODE_W-2:0]};
    end
endmodule

// File: rtl/adc_result_i2c_slave.sv
module adc_result_i2c_slave import adcsl_pkg::*; #(
    parameter int         DIFF_W      = 20,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [6:0] DEV_ADDR    = 7'b0010100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_pull_o,
    output logic                     conv_start_o,
    input  logic                     conv_done_i,
    input  logic signed [DIFF_W-1:0] conv_data_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic              scl_f, sda_f;
    logic [CODE_W-1:0] fmt_word;
    slv_state_t        d, q;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        adcsl_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    adcsl_fmt #(.DIFF_W(DIFF_W)) u_fmt (
        .val_i (conv_data_i),
        .word_o(fmt_word)
    );

    logic start_ev, stop_ev, rise_ev, fall_ev;
    assign start_ev = scl_f && q.scl_p && q.sda_p && !sda_f;
    assign stop_ev  = scl_f && q.scl_p && !q.sda_p && sda_f;
    assign rise_ev  = scl_f && !q.scl_p;
    assign fall_ev  = !scl_f && q.scl_p;

    always_comb begin
        d        = q;
        d.scl_p  = scl_f;
        d.sda_p  = sda_f;
        d.cstart = 1'b0;

        // Power-up conversion launch
        if (q.kick) begin
            d.kick   = 1'b0;
            d.cstart = 1'b1;
        end

        if (q.op == OP_CONV && conv_done_i) begin
            d.op  = OP_SLEEP;
            d.res = fmt_word;
        end

        if (start_ev) begin
            d.bus      = B_ADDR;
            d.cnt      = '0;
            d.pull     = 1'b0;
            d.rd_valid = 1'b0;
            if (q.op == OP_DOUT) d.op = OP_SLEEP;
        end else if (stop_ev) begin
            d.bus  = B_IDLE;
            d.pull = 1'b0;
            if (q.rd_valid) begin
                d.rd_valid = 1'b0;
                d.op       = OP_CONV;
                d.cstart   = 1'b1;
            end
        end else begin
            unique case (q.bus)
                B_ADDR: begin
                    if (rise_ev) begin
                        d.addr_sh = {q.addr_sh[6:0], sda_f};
                        d.cnt     = q.cnt + 4'd1;
                    end else if (fall_ev && q.cnt == 4'd8) begin
                        if (q.addr_sh == {DEV_ADDR, 1'b1} && q.op == OP_SLEEP) begin
                            d.pull     = 1'b1;
                            d.bus      = B_AACK;
                            d.op       = OP_DOUT;
                            d.rd_valid = 1'b1;
                            d.tx_sh    = q.res;
                            d.byte_hi  = 1'b0;
                        end else begin
                            d.bus = B_IDLE;
                        end
                    end
                end
                B_AACK: begin
                    if (fall_ev) begin
                        d.pull  = ~q.tx_sh[CODE_W-1];
                        d.tx_sh = q.tx_sh << 1;
                        d.cnt   = 4'd1;
                        d.bus   = B_TX;
                    end
                end
                B_TX: begin
                    if (fall_ev) begin
                        if (q.cnt == 4'd8) begin
                            d.pull = 1'b0;
                            d.cnt  = '0;
                            if (q.byte_hi) begin
                                d.bus      = B_IDLE;
                                d.op       = OP_CONV;
                                d.rd_valid = 1'b0;
                                d.cstart   = 1'b1;
                            end else begin
                                d.bus = B_MACK;
                            end
                        end else begin
                            d.pull  = ~q.tx_sh[CODE_W-1];
                            d.tx_sh = q.tx_sh << 1;
                            d.cnt   = q.cnt + 4'd1;
                        end
                    end
                end
                B_MACK: begin
                    if (rise_ev) begin
                        d.mack = !sda_f;
                    end else if (fall_ev) begin
                        if (q.mack) begin
                            d.byte_hi = 1'b1;
                            d.pull    = ~q.tx_sh[CODE_W-1];
                            d.tx_sh   = q.tx_sh << 1;
                            d.cnt     = 4'd1;
                            d.bus     = B_TX;
                        end else begin
                            d.bus = B_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.op       <= OP_CONV;
            q.bus      <= B_IDLE;
            q.kick     <= 1'b1;
            q.scl_p    <= 1'b1;
            q.sda_p    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o   = q.pull;
    assign conv_start_o = q.cstart;
endmodule

// File: rtl/adcsl_checker.sv
module adcsl_checker import adcsl_pkg::*; (
    input logic clk,
    input logic rst_n,
    input logic sda_pull,
    input logic conv_start,
    input logic conv_done,
    input logic scl_f,
    input op_e  op
);
    // R6: pull-down enable frozen while the filtered clock stays high
    p_sda_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_pull));

    // R3: nothing is driven on the bus while converting
    p_nak_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CONV) |-> !sda_pull);

    // R12: start is a single-cycle pulse
    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R12: start only together with the converting state
    p_start_conv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (op == OP_CONV));

    // R2: done moves the block to sleep
    p_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CONV && conv_done) |=> (op == OP_SLEEP));
endmodule

bind adc_result_i2c_slave adcsl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull_o),
    .conv_start(conv_start_o),
    .conv_done (conv_done_i),
    .scl_f     (scl_f),
    .op        (q.op)
);

// File: tb/adc_result_i2c_slave_bench.sv
`timescale 1ns/1ps
module adc_result_i2c_slave_bench;
    localparam int DIFF_W   = 20;
    localparam int Q        = 25;
    localparam int CONV_CYC = 2000;
    localparam int NV       = 8;
    localparam int VEC_IN [NV] = '{0, -1, 1, 32767, 40000, -32768, -100000, 12345};
    localparam logic [15:0] VEC_EXP [NV] =
        '{16'h8000, 16'h7FFF, 16'h8001, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'hB039};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, conv_start, conv_done;
    logic signed [DIFF_W-1:0] conv_data;
    logic signed [DIFF_W-1:0] stub_val;
    wire sda_line = sda_m & ~sda_pull;

    int errors = 0, checks = 0, starts = 0, start_hi = 0;
    int stub_cnt = 0;
    logic stub_busy = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    adc_result_i2c_slave #(.DIFF_W(DIFF_W)) u_adc_result_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .conv_start_o(conv_start),
        .conv_done_i(conv_done), .conv_data_i(conv_data)
    );

    // Fixed-delay converter core stub
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            stub_busy <= 1'b0;
        end else if (conv_start) begin
            stub_busy <= 1'b1;
            stub_cnt  <= CONV_CYC;
        end else if (stub_busy) begin
            if (stub_cnt == 0) begin
                stub_busy <= 1'b0;
                conv_done <= 1'b1;
                conv_data <= stub_val;
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
        if (rst_n && conv_start) start_hi++;
    end

    always @(posedge conv_start) starts++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
        ack = ~sda_line;
        wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
        end
        sda_m = ~give_ack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
        sda_m = 1'b1;
    endtask

    initial begin
        logic ack;
        logic [7:0] hi, lo;
        int s0;
        stub_val = VEC_IN[0][DIFF_W-1:0];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 line released after reset", 32'(sda_pull), 32'd0);
        chk("R2 one start after reset", 32'(starts), 32'd1);

        // Addressed while the first conversion runs
        bus_start(); send_byte(8'h29, ack); bus_stop();
        chk("R3 NAK while converting", 32'(ack), 32'd0);
        repeat (3000) @(negedge clk);

        // Vector table: full two-byte reads
        for (int i = 0; i < NV; i++) begin
            bus_start(); send_byte(8'h29, ack);
            chk("R4 ACK in sleep", 32'(ack), 32'd1);
            s0 = starts;
            recv_byte(1'b1, hi); recv_byte(1'b0, lo);
            chk("R5 R6 R7 word", 32'({hi, lo}), 32'(VEC_EXP[i]));
            chk("R10 start after 16 bits", 32'(starts), 32'(s0 + 1));
            bus_stop();
            chk("R10 no extra start on STOP", 32'(starts), 32'(s0 + 1));
            if (i + 1 < NV) stub_val = VEC_IN[i+1][DIFF_W-1:0];
            else stub_val = 20'sd100;
            if (i == NV - 1) begin
                // next conversion is running: address is refused
                bus_start(); send_byte(8'h29, ack); bus_stop();
                chk("R3 NAK after readout", 32'(ack), 32'd0);
                stub_val = VEC_IN[NV-1][DIFF_W-1:0];
            end
            repeat (2500) @(negedge clk);
        end

        // Wrong address and write bit are ignored
        s0 = starts;
        bus_start(); send_byte(8'h2B, ack); bus_stop();
        chk("R1 wrong address NAK", 32'(ack), 32'd0);
        bus_start(); send_byte(8'h28, ack); bus_stop();
        chk("R1 write bit NAK", 32'(ack), 32'd0);
        chk("R1 no start from ignored frames", 32'(starts), 32'(s0));
        bus_start(); send_byte(8'h29, ack);
        chk("R1 still ACKs after ignored frames", 32'(ack), 32'd1);
        recv_byte(1'b1, hi); recv_byte(1'b0, lo); bus_stop();
        chk("R1 held result unchanged", 32'({hi, lo}), 32'h0000B039);
        stub_val = 20'sd100;
        repeat (2500) @(negedge clk);

        // Partial read closed by NACK then STOP
        s0 = starts;
        bus_start(); send_byte(8'h29, ack); recv_byte(1'b0, hi);
        chk("R8 first byte", 32'(hi), 32'h80);
        chk("R8 line released after NACK", 32'(sda_pull), 32'd0);
        chk("R8 no start before STOP", 32'(starts), 32'(s0));
        bus_stop();
        chk("R9 start on STOP after partial read", 32'(starts), 32'(s0 + 1));
        stub_val = 20'sd200;
        bus_start(); send_byte(8'h29, ack); bus_stop();
        chk("R3 NAK after STOP-launched start", 32'(ack), 32'd0);
        repeat (2500) @(negedge clk);

        // Address ACK then STOP with nothing read
        s0 = starts;
        bus_start(); send_byte(8'h29, ack);
        chk("R4 ACK before empty read", 32'(ack), 32'd1);
        bus_stop();
        chk("R9 start on STOP with zero bits read", 32'(starts), 32'(s0 + 1));
        stub_val = -20'sd5;
        repeat (2500) @(negedge clk);

        // Repeated START after a partial read
        s0 = starts;
        bus_start(); send_byte(8'h29, ack); recv_byte(1'b0, hi);
        chk("R11 first byte before repeated START", 32'(hi), 32'h7F);
        bus_start(); send_byte(8'h29, ack);
        chk("R11 ACK after repeated START", 32'(ack), 32'd1);
        recv_byte(1'b1, hi); recv_byte(1'b0, lo); bus_stop();
        chk("R11 same word reread", 32'({hi, lo}), 32'h00007FFB);
        chk("R11 one start for the sequence", 32'(starts), 32'(s0 + 1));
        chk("R12 every start one cycle wide", 32'(start_hi), 32'(starts));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule